// File: doc/BRIEF.md
# Raster Timing Generator with Overlay Windows

This block generates display timing from a free-running pixel counter (X) and line counter (Y). Software programs every boundary as an inclusive corner coordinate. The programmable boundaries are the raster extent, the visible display area and three overlay windows. The block drives horizontal and vertical sync, a display-enable flag and one window-active flag per overlay channel.

It also watches four programmable lines and latches a status bit when the raster reaches each one. The status bits are maskable onto a single interrupt line and are cleared by writing ones. Two further programmable lines produce one-cycle reload strobes, one for single-buffered and one for double-buffered register sets. A downstream context loader uses these strobes; the block itself only signals them.

Configuration uses a plain 32-bit write port and a read port with one cycle of latency. Geometry registers are shadowed, so a change made during a frame takes effect from the next frame.

Top module: `rtg_top`

## Requirements
- R1: While reset is high and after it, all outputs are low and every register reads as zero.
- R2: X counts from 0 up to the raster X limit and then returns to 0, advancing Y. Y returns to 0 after the Y limit, so a frame lasts (limX+1)*(limY+1) cycles. The raster register is at byte 0x04. All coordinate registers hold X in bits 12:0 and Y in bits 28:16.
- R3: hsync is high while X is below the sync X length and vsync is high while Y is below the sync Y length. The sync register is at 0x2C.
- R4: disp_en is high when X and Y are inside the inclusive box formed by the upper-left corner at 0x08 and the lower-right corner at 0x0C.
- R5: Overlay channel k (k=0..2) has its upper-left corner at 0x10+8k and its lower-right corner at 0x14+8k. Its ch_win bit is high when the position is inside that inclusive box and its enable bit is set. The enable bits sit in the control register at 0x00: bit 2 for k=0, bit 1 for k=1, bit 0 for k=2. A channel whose corners are both zero is never active.
- R6: Control bit 8 runs the raster. When it is clear, both counters are held at zero and the timing outputs and strobes go low on the next cycle. When it is set again, counting restarts from (0,0).
- R7: Line watch j (j=0..3) takes its line from bits 28:16 at 0x30+4j. When the raster is at X=0 on that line, status bit j is set. The status register reads at 0x40.
- R8: Writing ones to 0x44 clears the matching status bits. A bit that is set in the same cycle as it is cleared stays set.
- R9: irq is high whenever any status bit is set together with its mask bit. The mask register is at 0x48, bits 3:0.
- R10: db_reload pulses for one cycle at X=0 of the line held in bits 12:0 of 0x28. sb_reload does the same for the line held in bits 28:16 of 0x28.
- R11: Writes to the raster, sync, corner, reload-line and watch-line registers take effect after the current frame's last pixel. While the raster is stopped they take effect at once.
- R12: A read issued with rd_en returns the stored register value on rd_data in the following cycle. Each timing output is registered and reflects the counter position of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Inside display area |
| ch_win | output | 3 | Overlay window active, one bit per channel |
| irq | output | 1 | Masked line-watch interrupt |
| db_reload | output | 1 | Double-buffer reload strobe |
| sb_reload | output | 1 | Single-buffer reload strobe |

## Verification
The geometry is exercised with overlay windows placed well inside the display, with a window whose edges coincide with the display's lower-right corner, and with an enabled window whose corners are all zero. These cases separate inclusive from exclusive bounds and show that the all-zero rule overrides the enable bit. The raster and display corners are rewritten in the middle of a frame, and the sync outputs and window counts show whether the change waits for the frame boundary. The status bits are tested with plain clears, with a clear that lands in the same cycle as a line match, and with the mask covering only alternate bits. A stop and restart of the raster confirms that the outputs drop and that counting resumes from the origin.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int COORD_W = 13;
  localparam int Y_LSB   = 16;

  typedef struct packed {
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] x;
  } xy_t;

  function automatic xy_t word_to_xy(input logic [31:0] w);
    xy_t r;
    r.x = w[COORD_W-1:0];
    r.y = w[Y_LSB+COORD_W-1:Y_LSB];
    return r;
  endfunction

  function automatic logic in_box(input logic [COORD_W-1:0] px, input logic [COORD_W-1:0] py,
                                  input xy_t ul, input xy_t lr);
    return (px >= ul.x) && (px <= lr.x) && (py >= ul.y) && (py <= lr.y);
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int NLINE = 4,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  input  logic             reload,
  input  logic [NLINE-1:0] irq_stat,
  output logic             run,
  output logic [NCH-1:0]   ch_en,
  output logic [NLINE-1:0] irq_mask,
  output logic [NLINE-1:0] irq_clr,
  output xy_t              total,
  output xy_t              dul,
  output xy_t              dlr,
  output xy_t              sync_len,
  output xy_t              trig,
  output xy_t              ch_ul [NCH],
  output xy_t              ch_lr [NCH],
  output logic [COORD_W-1:0] line_y [NLINE]
);
  localparam int IDX_CH   = 4;
  localparam int IDX_TRIG = IDX_CH + 2*NCH;
  localparam int IDX_SYNC = IDX_TRIG + 1;
  localparam int IDX_LINE = IDX_SYNC + 1;
  localparam int IDX_STAT = IDX_LINE + NLINE;
  localparam int IDX_CLR  = IDX_STAT + 1;
  localparam int IDX_MASK = IDX_CLR + 1;
  localparam int NWORD    = IDX_MASK + 1;
  localparam int IW       = $clog2(NWORD);
  localparam int RUN_BIT  = 8;

  logic [31:0] cfg [NWORD];
  logic [31:0] shd [NWORD];

  logic [IW-1:0] wi, ri;
  logic          w_ok, r_ok;

  assign wi   = wr_addr[IW+1:2];
  assign ri   = rd_addr[IW+1:2];
  assign w_ok = (wr_addr[AW-1:IW+2] == '0) && (int'(wi) < NWORD);
  assign r_ok = (rd_addr[AW-1:IW+2] == '0) && (int'(ri) < NWORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORD; i++) begin
        cfg[i] <= '0;
        shd[i] <= '0;
      end
    end else begin
      if (reload) begin
        for (int i = 0; i < NWORD; i++) shd[i] <= cfg[i];
      end
      if (wr_en && w_ok && int'(wi) != IDX_STAT && int'(wi) != IDX_CLR)
        cfg[wi] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (!r_ok)                    rd_data <= '0;
      else if (int'(ri) == IDX_STAT) rd_data <= {{(32-NLINE){1'b0}}, irq_stat};
      else                          rd_data <= cfg[ri];
    end
  end

  assign irq_clr  = (wr_en && w_ok && int'(wi) == IDX_CLR) ? wr_data[NLINE-1:0] : '0;
  assign run      = cfg[0][RUN_BIT];
  assign irq_mask = cfg[IDX_MASK][NLINE-1:0];
  assign total    = word_to_xy(shd[1]);
  assign dul      = word_to_xy(shd[2]);
  assign dlr      = word_to_xy(shd[3]);
  assign trig     = word_to_xy(shd[IDX_TRIG]);
  assign sync_len = word_to_xy(shd[IDX_SYNC]);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_en[k] = cfg[0][NCH-1-k];
    assign ch_ul[k] = word_to_xy(shd[IDX_CH + 2*k]);
    assign ch_lr[k] = word_to_xy(shd[IDX_CH + 2*k + 1]);
  end

  for (genvar j = 0; j < NLINE; j++) begin : g_line
    xy_t lw;
    assign lw        = word_to_xy(shd[IDX_LINE + j]);
    assign line_y[j] = lw.y;
  end
endmodule

// File: rtl/rtg_raster.sv
module rtg_raster
  import rtg_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [NCH-1:0]     ch_en,
  input  xy_t                total,
  input  xy_t                dul,
  input  xy_t                dlr,
  input  xy_t                sync_len,
  input  xy_t                ch_ul [NCH],
  input  xy_t                ch_lr [NCH],
  output logic [COORD_W-1:0] cnt_x,
  output logic [COORD_W-1:0] cnt_y,
  output logic               frame_end,
  output logic               hsync,
  output logic               vsync,
  output logic               disp_en,
  output logic [NCH-1:0]     ch_win
);
  logic x_last, y_last;
  assign x_last    = (cnt_x == total.x);
  assign y_last    = (cnt_y == total.y);
  assign frame_end = run && x_last && y_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_x <= '0;
      cnt_y <= '0;
    end else if (x_last) begin
      cnt_x <= '0;
      cnt_y <= y_last ? '0 : cnt_y + 1'b1;
    end else begin
      cnt_x <= cnt_x + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      disp_en <= 1'b0;
    end else begin
      hsync   <= run && (cnt_x < sync_len.x);
      vsync   <= run && (cnt_y < sync_len.y);
      disp_en <= run && in_box(cnt_x, cnt_y, dul, dlr);
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_win
    logic blank;
    assign blank = (ch_ul[k] == '0) && (ch_lr[k] == '0);
    always_ff @(posedge clk) begin
      if (rst) ch_win[k] <= 1'b0;
      else     ch_win[k] <= run && ch_en[k] && !blank && in_box(cnt_x, cnt_y, ch_ul[k], ch_lr[k]);
    end
  end
endmodule

// File: rtl/rtg_linefx.sv
module rtg_linefx
  import rtg_pkg::*;
#(
  parameter int NLINE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [COORD_W-1:0] cnt_x,
  input  logic [COORD_W-1:0] cnt_y,
  input  logic [COORD_W-1:0] line_y [NLINE],
  input  xy_t                trig,
  input  logic [NLINE-1:0]   irq_clr,
  input  logic [NLINE-1:0]   irq_mask,
  output logic [NLINE-1:0]   irq_stat,
  output logic               irq,
  output logic               db_reload,
  output logic               sb_reload
);
  logic            line_head;
  logic [NLINE-1:0] hit;

  assign line_head = run && (cnt_x == '0);

  for (genvar j = 0; j < NLINE; j++) begin : g_hit
    assign hit[j] = line_head && (cnt_y == line_y[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_stat  <= '0;
      db_reload <= 1'b0;
      sb_reload <= 1'b0;
    end else begin
      irq_stat  <= (irq_stat & ~irq_clr) | hit;
      db_reload <= line_head && (cnt_y == trig.x);
      sb_reload <= line_head && (cnt_y == trig.y);
    end
  end

  assign irq = |(irq_stat & irq_mask);
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int NLINE = 4,
  parameter int AW    = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [31:0]    rd_data,
  output logic           hsync,
  output logic           vsync,
  output logic           disp_en,
  output logic [NCH-1:0] ch_win,
  output logic           irq,
  output logic           db_reload,
  output logic           sb_reload
);
  logic               run, frame_end, reload;
  logic [NCH-1:0]     ch_en;
  logic [NLINE-1:0]   irq_mask, irq_clr, irq_stat;
  xy_t                total, dul, dlr, sync_len, trig;
  xy_t                ch_ul [NCH];
  xy_t                ch_lr [NCH];
  logic [COORD_W-1:0] line_y [NLINE];
  logic [COORD_W-1:0] cnt_x, cnt_y;

  assign reload = !run || frame_end;

  rtg_regs #(.NCH(NCH), .NLINE(NLINE), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .reload(reload), .irq_stat(irq_stat),
    .run(run), .ch_en(ch_en), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .total(total), .dul(dul), .dlr(dlr), .sync_len(sync_len), .trig(trig),
    .ch_ul(ch_ul), .ch_lr(ch_lr), .line_y(line_y)
  );

  rtg_raster #(.NCH(NCH)) u_raster (
    .clk(clk), .rst(rst), .run(run), .ch_en(ch_en),
    .total(total), .dul(dul), .dlr(dlr), .sync_len(sync_len),
    .ch_ul(ch_ul), .ch_lr(ch_lr),
    .cnt_x(cnt_x), .cnt_y(cnt_y), .frame_end(frame_end),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .ch_win(ch_win)
  );

  rtg_linefx #(.NLINE(NLINE)) u_linefx (
    .clk(clk), .rst(rst), .run(run), .cnt_x(cnt_x), .cnt_y(cnt_y),
    .line_y(line_y), .trig(trig), .irq_clr(irq_clr), .irq_mask(irq_mask),
    .irq_stat(irq_stat), .irq(irq), .db_reload(db_reload), .sb_reload(sb_reload)
  );
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
  import rtg_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int NLINE = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic [COORD_W-1:0] cnt_x,
  input logic [COORD_W-1:0] lim_x,
  input logic               hsync,
  input logic               vsync,
  input logic               disp_en,
  input logic [NCH-1:0]     ch_win,
  input logic               db_reload,
  input logic               sb_reload,
  input logic [NLINE-1:0]   irq_stat,
  input logic [NLINE-1:0]   irq_clr
);
  // R6
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!hsync && !vsync && !disp_en && ch_win == '0 && !db_reload && !sb_reload));

  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && cnt_x != '0) |-> (cnt_x == $past(cnt_x) + 1'b1));

  // R2
  x_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_x <= lim_x);

  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(irq_stat) & ~irq_stat & ~$past(irq_clr)) == '0));

  // R6
  disp_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> $past(run));
endmodule

bind rtg_top rtg_chk #(.NCH(NCH), .NLINE(NLINE)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cnt_x(cnt_x), .lim_x(total.x),
  .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .ch_win(ch_win),
  .db_reload(db_reload), .sb_reload(sb_reload),
  .irq_stat(irq_stat), .irq_clr(irq_clr)
);

// File: tb/rtg_top_test.sv
module rtg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hsync, vsync, disp_en, irq, db_reload, sb_reload;
  logic [2:0]  ch_win;

  int total = 0, bad = 0;
  bit cmp_en = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtg_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .ch_win(ch_win),
    .irq(irq), .db_reload(db_reload), .sb_reload(sb_reload)
  );

  // behavioural reference
  int unsigned cfg [NW];
  int unsigned shd [NW];
  int mx, my;
  int unsigned stat;
  bit e_hs, e_vs, e_de, e_irq, e_db, e_sb;
  bit [2:0] e_win;
  int unsigned e_rd;

  function automatic int fx(input int unsigned w); return int'(w & 32'h1FFF); endfunction
  function automatic int fy(input int unsigned w); return int'((w >> 16) & 32'h1FFF); endfunction
  function automatic int unsigned xy(input int x, input int y);
    return (int'(y) << 16) | int'(x);
  endfunction
  function automatic bit inside_box(input int x, input int y, input int unsigned ul, input int unsigned lr);
    return x >= fx(ul) && x <= fx(lr) && y >= fy(ul) && y <= fy(lr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) begin cfg[i] = 0; shd[i] = 0; end
      mx = 0; my = 0; stat = 0; e_rd = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_win = 0; e_db = 0; e_sb = 0; e_irq = 0;
    end else begin
      bit run, fe;
      int widx, ridx;
      int unsigned clr, sets;
      run  = cfg[0][8];
      ridx = int'(rd_addr) / 4;
      widx = int'(wr_addr) / 4;
      if (rd_en) e_rd = (ridx == 16) ? stat : (ridx < NW ? cfg[ridx] : 0);
      e_hs = run && mx < fx(shd[11]);
      e_vs = run && my < fy(shd[11]);
      e_de = run && inside_box(mx, my, shd[2], shd[3]);
      for (int k = 0; k < 3; k++)
        e_win[k] = run && cfg[0][2-k] && !(shd[4+2*k] == 0 && shd[5+2*k] == 0)
                   && inside_box(mx, my, shd[4+2*k], shd[5+2*k]);
      sets = 0;
      for (int j = 0; j < 4; j++)
        if (run && mx == 0 && my == fy(shd[12+j])) sets |= (1 << j);
      clr  = (wr_en && widx == 17) ? (wr_data & 32'hF) : 0;
      stat = (stat & ~clr) | sets;
      e_db = run && mx == 0 && my == fx(shd[10]);
      e_sb = run && mx == 0 && my == fy(shd[10]);
      fe = run && mx == fx(shd[1]) && my == fy(shd[1]);
      if (!run) begin mx = 0; my = 0; end
      else if (mx == fx(shd[1])) begin mx = 0; my = (my == fy(shd[1])) ? 0 : my + 1; end
      else mx = mx + 1;
      if (!run || fe) for (int i = 0; i < NW; i++) shd[i] = cfg[i];
      if (wr_en && widx < NW && widx != 16 && widx != 17) cfg[widx] = wr_data;
      e_irq = (stat & cfg[18] & 32'hF) != 0;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check("R3 hsync", hsync, e_hs);
      check("R3 vsync", vsync, e_vs);
      check("R4 disp_en", disp_en, e_de);
      check("R5 ch_win", ch_win, e_win);
      check("R9 irq", irq, e_irq);
      check("R10 db_reload", db_reload, e_db);
      check("R10 sb_reload", sb_reload, e_sb);
      check("R12 rd_data", rd_data, e_rd);
    end
  end

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk); wr_en = 1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int unsigned d);
    @(negedge clk); rd_en = 1; rd_addr = 8'(a);
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic wait_pos(input int x, input int y);
    do @(negedge clk); while (!(mx == x && my == y));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned v;
    int n_de, n_c1, n_c3, n_db, n_sb, gap;
    repeat (4) @(negedge clk);
    // R1 outputs quiet in reset
    check("R1 outputs in reset", {hsync, vsync, disp_en, ch_win, irq, db_reload, sb_reload}, 0);
    rst = 0;
    cmp_en = 1;
    rd(8'h04, v); check("R1 raster reg after reset", v, 0);

    wr(8'h04, xy(19, 11));
    wr(8'h2C, xy(3, 2));
    wr(8'h08, xy(5, 3));
    wr(8'h0C, xy(16, 9));
    wr(8'h10, xy(6, 4));  wr(8'h14, xy(10, 6));
    wr(8'h18, xy(12, 5)); wr(8'h1C, xy(16, 9));
    wr(8'h20, 0);         wr(8'h24, 0);
    wr(8'h28, xy(9, 0));
    wr(8'h30, xy(0, 0)); wr(8'h34, xy(0, 3)); wr(8'h38, xy(0, 7)); wr(8'h3C, xy(0, 11));
    wr(8'h48, 32'h5);
    rd(8'h0C, v); check("R12 readback display corner", v, xy(16, 9));
    wr(8'h00, 32'h107);

    // R4 R5 R10 one full frame of counts
    wait_pos(0, 0);
    n_de = 0; n_c1 = 0; n_c3 = 0; n_db = 0; n_sb = 0;
    for (int i = 0; i < 240; i++) begin
      @(negedge clk);
      n_de += disp_en; n_c1 += ch_win[0]; n_c3 += ch_win[2];
      n_db += db_reload; n_sb += sb_reload;
    end
    check("R4 display cells per frame", n_de, 84);
    check("R5 ch1 cells per frame", n_c1, 15);
    check("R5 zero-corner channel never active", n_c3, 0);
    check("R10 db pulses per frame", n_db, 1);
    check("R10 sb pulses per frame", n_sb, 1);

    // R2 hsync period
    do @(negedge clk); while (hsync);
    do @(negedge clk); while (!hsync);
    gap = 0;
    do begin @(negedge clk); gap++; end while (hsync);
    do begin @(negedge clk); gap++; end while (!hsync);
    check("R2 line length", gap, 20);

    // R7 R9 all lines hit
    rd(8'h40, v); check("R7 status after frame", v, 32'hF);
    check("R9 irq with mask", irq, 1);

    // R8 plain clear
    wait_pos(5, 1);
    wr(8'h44, 32'h5);
    rd(8'h40, v); check("R8 w1c", v, 32'hA);
    check("R9 irq masked off", irq, 0);

    // R8 clear colliding with set of bit 1 (line 3)
    wait_pos(0, 3);
    wr_en = 1; wr_addr = 8'h44; wr_data = 32'h2;
    @(negedge clk); wr_en = 0;
    rd(8'h40, v); check("R8 set wins over clear", v & 32'h2, 32'h2);

    // R11 shadowed display corner change mid-frame
    wait_pos(5, 5);
    wr(8'h0C, xy(10, 9));
    wait_pos(0, 0);
    n_de = 0;
    for (int i = 0; i < 240; i++) begin @(negedge clk); n_de += disp_en; end
    check("R11 new display size next frame", n_de, 42);

    // R6 stop and restart
    wr(8'h00, 32'h007);
    @(negedge clk);
    check("R6 outputs low when stopped", {hsync, vsync, disp_en, ch_win, db_reload, sb_reload}, 0);
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h107);
    @(negedge clk);
    check("R6 restart at origin", {hsync, vsync}, 2'b11);

    // R11 R2 raster size change mid-frame
    wait_pos(7, 2);
    wr(8'h04, xy(9, 5));
    repeat (600) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule